// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Vectoring

This block keeps a matrix of pending interrupt requests: seven priority levels (numbered 1 to 7) with 32 request lines each. Every cycle it compares the requests against the processor's current priority and raises a registered pending flag whenever some request could be taken. When the processor strobes acknowledge, the block chooses the single winning request, clears that request bit, and returns the interrupt vector held for that level and line in a programmable vector table.

Request bits are raised and dropped through dedicated set and clear ports, and the vector table is loaded through a write port. A mode input chooses between two ways of judging eligibility. In the unrestricted mode every request at a level above the processor priority competes. In the restricted mode, once the processor priority reaches a threshold level, only lines marked as internal (processor-side) sources in a per-level mask still compete, since external devices are all seen as one low request level. On each level one line is reserved for a software-programmed interrupt; that line always counts as internal, and its vector entry starts out at a common preset value.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After a synchronous reset no request is pending, `irq_pending`, `vec_valid` and `vec_out` are all 0, and the vector table holds 0 except on the reserved line described in R8.
- R2: A request at level L is eligible only when L is strictly greater than `cur_pri`. `irq_pending` shows, one cycle later, whether any eligible request existed. With `cur_pri` = 7 nothing is ever eligible.
- R3: Among the eligible requests, the highest level wins.
- R4: Within the winning level, the lowest-numbered set line (0 to 31) wins.
- R5: An `ack` makes `vec_valid` high in the next cycle, with `vec_out` equal to the table entry for the winning level and line, and clears that one request bit.
- R6: An `ack` with no eligible request gives `vec_valid` = 1 and `vec_out` = 0 in the next cycle, and leaves every request bit unchanged.
- R7: With `restrict_mode` = 1 and `cur_pri` at or above the threshold (default 4), only lines in the internal mask are eligible. The default mask is lines 0 and 16 on every level. With `restrict_mode` = 0, or with `cur_pri` below the threshold, all lines are eligible.
- R8: Line 16 of every level is the programmed-interrupt line. Its table entry resets to the common vector 0x00A0, and it is always treated as internal.
- R9: When a set and a clear, or a set and an acknowledge, hit the same request bit in the same cycle, the bit ends up set.
- R10: A table write with a level from 1 to 7 replaces the entry for that level and line, and later acknowledges of that request return the new value. Level 0 on the set, clear and write ports has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pri | input | 3 | Current processor priority, 0 to 7 |
| restrict_mode | input | 1 | 1 selects restricted eligibility at or above the threshold |
| set_en | input | 1 | Set one request bit |
| set_level | input | 3 | Level of the bit to set (1 to 7) |
| set_line | input | 5 | Line of the bit to set |
| clr_en | input | 1 | Clear one request bit |
| clr_level | input | 3 | Level of the bit to clear (1 to 7) |
| clr_line | input | 5 | Line of the bit to clear |
| vwr_en | input | 1 | Write one vector table entry |
| vwr_level | input | 3 | Level of the entry (1 to 7) |
| vwr_line | input | 5 | Line of the entry |
| vwr_data | input | 16 | Vector value to store |
| ack | input | 1 | Acknowledge strobe from the processor |
| irq_pending | output | 1 | Registered: an eligible request exists |
| vec_valid | output | 1 | Pulses one cycle after each acknowledge |
| vec_out | output | 16 | Vector returned for the last acknowledge |

## Verification
The hardest case to reach from the ports is a restricted-mode window: several external and internal requests are pending at once while the priority sits at or above the threshold, so that a higher-level external request must lose to a lower-level internal one and must then win again once the priority drops. The bench builds up mixed request patterns through the set port and sweeps every priority in both modes. It drains each pattern with acknowledges, and a cycle-accurate model in the bench predicts each returned vector from a table with a distinct value loaded for every entry.

// File: rtl/iva_pkg.sv
package iva_pkg;
    localparam int unsigned NLVL  = 7;
    localparam int unsigned NLINE = 32;
    localparam int unsigned VW    = 16;
    localparam int unsigned LW    = $clog2(NLVL + 1);
    localparam int unsigned BW    = $clog2(NLINE);

    typedef logic [LW-1:0]    lvl_t;
    typedef logic [BW-1:0]    line_t;
    typedef logic [VW-1:0]    vec_t;
    typedef logic [NLVL-1:0][NLINE-1:0] reqmat_t;

    typedef struct packed {
        logic  en;
        lvl_t  level;
        line_t line;
    } bitop_t;

    typedef struct packed {
        logic  valid;
        lvl_t  level;
        line_t line;
    } grant_t;

    localparam reqmat_t DEF_INT_MASK = {NLVL{NLINE'(32'h0001_0001)}};

    function automatic reqmat_t decode_op(bitop_t op);
        reqmat_t m;
        m = '0;
        for (int l = 0; l < int'(NLVL); l++) begin
            if (op.en && op.level == lvl_t'(l + 1)) m[l][op.line] = 1'b1;
        end
        return m;
    endfunction

    function automatic reqmat_t with_soft(reqmat_t mask, int unsigned soft_line);
        reqmat_t m;
        m = mask;
        for (int l = 0; l < int'(NLVL); l++) m[l][soft_line] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/iva_req_array.sv
module iva_req_array
    import iva_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bitop_t  set_op,
    input  bitop_t  clr_op,
    input  bitop_t  ack_op,
    output reqmat_t req_q
);
    reqmat_t setm, clrm, ackm;

    always_comb begin
        setm = decode_op(set_op);
        clrm = decode_op(clr_op);
        ackm = decode_op(ack_op);
    end

    // set is applied last so it overrides clear and acknowledge on the same bit
    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= (req_q & ~clrm & ~ackm) | setm;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) set_op.en |=> ((req_q & $past(setm)) == $past(setm))); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst) ack_op.en |=> ((req_q & $past(ackm & ~setm)) == '0)); // R5
endmodule

// File: rtl/iva_select.sv
module iva_select
    import iva_pkg::*;
#(
    parameter int unsigned THRESH   = 4,
    parameter reqmat_t     INT_MASK = DEF_INT_MASK
) (
    input  logic    clk,
    input  logic    rst,
    input  reqmat_t req,
    input  lvl_t    cur_pri,
    input  logic    restrict_mode,
    output grant_t  grant
);
    logic    restricted;
    reqmat_t elig;

    always_comb begin
        restricted = restrict_mode && (cur_pri >= lvl_t'(THRESH));
        for (int l = 0; l < int'(NLVL); l++) begin
            elig[l] = req[l] & (restricted ? INT_MASK[l] : {NLINE{1'b1}});
            if (!(lvl_t'(l + 1) > cur_pri)) elig[l] = '0;
        end
    end

    // ascending level scan keeps the highest, descending line scan keeps the lowest
    always_comb begin
        grant = '0;
        for (int l = 0; l < int'(NLVL); l++) begin
            if (|elig[l]) begin
                grant.valid = 1'b1;
                grant.level = lvl_t'(l + 1);
                for (int b = int'(NLINE) - 1; b >= 0; b--) begin
                    if (elig[l][b]) grant.line = line_t'(b);
                end
            end
        end
    end

    AST_WIN_ABOVE_PRI: assert property (@(posedge clk) disable iff (rst) grant.valid |-> (grant.level > cur_pri)); // R2
    AST_TOP_PRI_IDLE: assert property (@(posedge clk) disable iff (rst) (cur_pri == lvl_t'(NLVL)) |-> !grant.valid); // R2
    AST_WIN_REQUESTED: assert property (@(posedge clk) disable iff (rst) grant.valid |-> req[grant.level - lvl_t'(1)][grant.line]); // R3
    AST_RESTRICT_MASK: assert property (@(posedge clk) disable iff (rst) (restricted && grant.valid) |-> INT_MASK[grant.level - lvl_t'(1)][grant.line]); // R7
endmodule

// File: rtl/iva_vec_table.sv
module iva_vec_table
    import iva_pkg::*;
#(
    parameter int unsigned SOFT_LINE = 16,
    parameter vec_t        SOFT_VEC  = 16'h00A0
) (
    input  logic   clk,
    input  logic   rst,
    input  bitop_t wr_op,
    input  vec_t   wr_data,
    input  lvl_t   rd_level,
    input  line_t  rd_line,
    output vec_t   rd_data
);
    vec_t tab [NLVL][NLINE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < int'(NLVL); l++)
                for (int b = 0; b < int'(NLINE); b++)
                    tab[l][b] <= (b == int'(SOFT_LINE)) ? SOFT_VEC : '0;
        end else if (wr_op.en && wr_op.level != '0) begin
            tab[wr_op.level - lvl_t'(1)][wr_op.line] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_level != '0) rd_data = tab[rd_level - lvl_t'(1)][rd_line];
    end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
    import iva_pkg::*;
#(
    parameter int unsigned THRESH    = 4,
    parameter int unsigned SOFT_LINE = 16,
    parameter vec_t        SOFT_VEC  = 16'h00A0,
    parameter reqmat_t     INT_MASK  = DEF_INT_MASK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] cur_pri,
    input  logic          restrict_mode,
    input  logic          set_en,
    input  logic [LW-1:0] set_level,
    input  logic [BW-1:0] set_line,
    input  logic          clr_en,
    input  logic [LW-1:0] clr_level,
    input  logic [BW-1:0] clr_line,
    input  logic          vwr_en,
    input  logic [LW-1:0] vwr_level,
    input  logic [BW-1:0] vwr_line,
    input  logic [VW-1:0] vwr_data,
    input  logic          ack,
    output logic          irq_pending,
    output logic          vec_valid,
    output logic [VW-1:0] vec_out
);
    localparam reqmat_t EFF_MASK = with_soft(INT_MASK, SOFT_LINE);

    reqmat_t req_q;
    grant_t  grant;
    bitop_t  set_op, clr_op, ack_op, wr_op;
    vec_t    tab_rd;
    logic    pend_q, vv_q;
    vec_t    vec_q;

    always_comb begin
        set_op = '{en: set_en, level: set_level, line: set_line};
        clr_op = '{en: clr_en, level: clr_level, line: clr_line};
        wr_op  = '{en: vwr_en, level: vwr_level, line: vwr_line};
        ack_op = '{en: ack && grant.valid, level: grant.level, line: grant.line};
    end

    iva_req_array u_req (
        .clk(clk), .rst(rst), .set_op(set_op), .clr_op(clr_op),
        .ack_op(ack_op), .req_q(req_q)
    );

    iva_select #(.THRESH(THRESH), .INT_MASK(EFF_MASK)) u_sel (
        .clk(clk), .rst(rst), .req(req_q), .cur_pri(cur_pri),
        .restrict_mode(restrict_mode), .grant(grant)
    );

    iva_vec_table #(.SOFT_LINE(SOFT_LINE), .SOFT_VEC(SOFT_VEC)) u_tab (
        .clk(clk), .rst(rst), .wr_op(wr_op), .wr_data(vwr_data),
        .rd_level(grant.level), .rd_line(grant.line), .rd_data(tab_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            vv_q   <= 1'b0;
            vec_q  <= '0;
        end else begin
            pend_q <= grant.valid;
            vv_q   <= ack;
            if (ack) vec_q <= grant.valid ? tab_rd : '0;
        end
    end

    assign irq_pending = pend_q;
    assign vec_valid   = vv_q;
    assign vec_out     = vec_q;

    AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (rst) ack |=> vec_valid); // R5
    AST_EMPTY_ACK_ZERO: assert property (@(posedge clk) disable iff (rst) (ack && !grant.valid) |=> (vec_out == '0)); // R6
    AST_EMPTY_ACK_KEEPS: assert property (@(posedge clk) disable iff (rst) (ack && !grant.valid && !set_en && !clr_en) |=> $stable(req_q)); // R6
endmodule

// File: tb/irq_vector_arbiter_bench.sv
`timescale 1ns/1ps
module irq_vector_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cur_pri;
    logic        restrict_mode;
    logic        set_en, clr_en, vwr_en, ack;
    logic [2:0]  set_level, clr_level, vwr_level;
    logic [4:0]  set_line, clr_line, vwr_line;
    logic [15:0] vwr_data;
    logic        irq_pending, vec_valid;
    logic [15:0] vec_out;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] mreq [7];
    logic [15:0] mvt  [7][32];
    logic [31:0] seed = 32'h1234_5678;
    localparam logic [31:0] IMASK = 32'h0001_0001;

    always #2.5 clk = ~clk;

    irq_vector_arbiter u_irq_vector_arbiter (
        .clk(clk), .rst(rst), .cur_pri(cur_pri), .restrict_mode(restrict_mode),
        .set_en(set_en), .set_level(set_level), .set_line(set_line),
        .clr_en(clr_en), .clr_level(clr_level), .clr_line(clr_line),
        .vwr_en(vwr_en), .vwr_level(vwr_level), .vwr_line(vwr_line), .vwr_data(vwr_data),
        .ack(ack), .irq_pending(irq_pending), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic model_win(output logic ok, output int wl, output int wb);
        logic [31:0] e;
        ok = 1'b0; wl = 0; wb = 0;
        for (int l = 1; l <= 7; l++) begin
            e = mreq[l-1] & ((restrict_mode && cur_pri >= 3'd4) ? IMASK : 32'hFFFF_FFFF);
            if (l <= int'(cur_pri)) e = '0;
            if (e != 0) begin
                ok = 1'b1; wl = l;
                for (int b = 31; b >= 0; b--) if (e[b]) wb = b;
            end
        end
    endtask

    task automatic step(input string tag);
        logic ok, eack;
        int wl, wb;
        logic [15:0] ev;
        model_win(ok, wl, wb);
        eack = ack;
        ev = ok ? mvt[wl-1][wb] : 16'h0;
        @(posedge clk); #1;
        if (eack && ok) mreq[wl-1][wb] = 1'b0;
        if (clr_en && clr_level != 0) mreq[clr_level-1][clr_line] = 1'b0;
        if (set_en && set_level != 0) mreq[set_level-1][set_line] = 1'b1;
        if (vwr_en && vwr_level != 0) mvt[vwr_level-1][vwr_line] = vwr_data;
        chk(tag, irq_pending === ok, irq_pending, ok);
        chk(tag, vec_valid === eack, vec_valid, eack);
        if (eack) chk(tag, vec_out === ev, vec_out, ev);
        ack = 0; set_en = 0; clr_en = 0; vwr_en = 0;
        @(negedge clk);
    endtask

    task automatic set_bit(input int l, input int b, input string tag);
        set_en = 1; set_level = 3'(l); set_line = 5'(b);
        step(tag);
    endtask

    task automatic do_ack(input string tag);
        ack = 1;
        step(tag);
    endtask

    initial begin
        #1000000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1; cur_pri = 0; restrict_mode = 0; ack = 0;
        set_en = 0; clr_en = 0; vwr_en = 0;
        set_level = 0; set_line = 0; clr_level = 0; clr_line = 0;
        vwr_level = 0; vwr_line = 0; vwr_data = 0;
        for (int l = 0; l < 7; l++) begin
            mreq[l] = '0;
            for (int b = 0; b < 32; b++) mvt[l][b] = (b == 16) ? 16'h00A0 : 16'h0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk("R1", irq_pending === 1'b0, irq_pending, 0);
        chk("R1", vec_valid === 1'b0, vec_valid, 0);
        chk("R1", vec_out === 16'h0, vec_out, 0);
        // R6 acknowledge with nothing pending
        do_ack("R6");
        // R8 preset vectors on the programmed line
        for (int l = 1; l <= 7; l++) begin
            set_bit(l, 16, "R8");
            do_ack("R8");
        end
        // R10 load a distinct vector everywhere else; level 0 write must be ignored
        for (int l = 1; l <= 7; l++)
            for (int b = 0; b < 32; b++)
                if (b != 16) begin
                    vwr_en = 1; vwr_level = 3'(l); vwr_line = 5'(b);
                    vwr_data = 16'h4000 | 16'(l << 8) | 16'(b << 1);
                    step("R10");
                end
        vwr_en = 1; vwr_level = 0; vwr_line = 3; vwr_data = 16'hDEAD; step("R10");
        set_en = 1; set_level = 0; set_line = 3; step("R10");
        do_ack("R10");
        // R2 strict comparison against the current priority
        cur_pri = 3; set_bit(3, 5, "R2"); step("R2");
        cur_pri = 2; step("R2");
        cur_pri = 7; step("R2"); do_ack("R2");
        cur_pri = 2; do_ack("R2");
        // R3 / R4 ordering
        cur_pri = 0;
        set_bit(2, 1, "R3"); set_bit(6, 20, "R3"); set_bit(5, 9, "R4"); set_bit(5, 4, "R4");
        do_ack("R3"); do_ack("R4"); do_ack("R4"); do_ack("R3"); do_ack("R6");
        // R7 restricted mode
        restrict_mode = 1; cur_pri = 4;
        set_bit(6, 5, "R7"); step("R7");
        set_bit(5, 0, "R7"); do_ack("R7"); do_ack("R7");
        cur_pri = 3; step("R7"); do_ack("R7");
        // R9 set beats clear and acknowledge on the same bit
        restrict_mode = 0; cur_pri = 0;
        set_en = 1; set_level = 4; set_line = 7; clr_en = 1; clr_level = 4; clr_line = 7;
        step("R9"); step("R9");
        ack = 1; set_en = 1; set_level = 4; set_line = 7; step("R9");
        step("R9");
        clr_en = 1; clr_level = 4; clr_line = 7; step("R9"); step("R9");
        // R10 rewrite one entry and read it back
        vwr_en = 1; vwr_level = 7; vwr_line = 2; vwr_data = 16'h0BEE; step("R10");
        set_bit(7, 2, "R10"); do_ack("R10");
        // sweep over modes, priorities and random patterns
        for (int rm = 0; rm < 2; rm++)
            for (int p = 0; p < 8; p++)
                for (int t = 0; t < 6; t++) begin
                    restrict_mode = rm[0]; cur_pri = 3'(p);
                    for (int k = 0; k < 4; k++) begin
                        logic [31:0] r;
                        r = rnd();
                        set_bit(int'(r[18:16] % 7) + 1, (r[20] ? int'(r[27:23]) : (r[21] ? 16 : 0)), rm ? "R7" : "R3");
                    end
                    for (int k = 0; k < 5; k++) do_ack(rm ? "R7" : "R4");
                end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule